// File: doc/BRIEF.md
# Sector Protection Mode Lock Unit

This unit holds the protection-mode configuration of a flash device. It keeps a four-bit one-time lock register, a 64-bit password stored as four 16-bit parts, and one lock flag per sector. Nonvolatile cells are modelled as registers that come out of reset as all ones. A cell can only be programmed from 1 to 0.

The unit takes command cycles that a bus front end has already decoded. Each cycle carries an operation code, an address and a data word. Software first enters one of three protection regions, then issues reads or two-cycle program sequences inside that region, and leaves with an explicit exit. While any region is open, `array_en` is low, which tells the surrounding logic not to serve array reads.

The persistent-mode bit and the password-mode bit are mutually exclusive. A program that would leave both of them at 0 is aborted. Once the OTP bit has been cleared, the lock register is frozen.

Top module: `prot_mode_lock`

## Requirements
- R1: After a synchronous active-low reset:
  - `lock_q` is 4'b1111, `array_en` is 1, `rd_valid` is 0 and `mode_pwd` is 0.
  - Every password bit and every sector flag is 1.
- R2: Operation codes are NOP=0, ENTRY=1, SETUP=2, PROG=3, READ=4 and EXIT=5.
  - ENTRY with `cmd_data[1:0]` = 0, 1 or 2 opens the lock, password or sector region respectively. The value 3 is ignored.
  - ENTRY is ignored while a region is already open.
  - `array_en` is 0 from the cycle after a region opens.
- R3: A PROG takes effect only when it comes immediately after a SETUP in the same open region. Any other PROG is ignored.
- R4: In the lock region, a READ makes `rd_valid` high for one cycle, with `rd_data` = {12'hFFF, lock}.
  - READ does nothing while no region is open.
  - A lock program ANDs `cmd_data[3:0]` into the register, so no bit returns to 1.
  - Bit 0 is the secure-sector lock, bit 1 the persistent-mode lock, bit 2 the password-mode lock and bit 3 the OTP bit.
- R5: A lock program whose result would have bit 1 and bit 2 both at 0 is aborted and leaves the register unchanged.
- R6: `mode_pwd` is 1 exactly when lock bit 2 is 0. Otherwise the unit is in persistent mode.
- R7: Once lock bit 3 is 0, every further lock program is ignored.
- R8: In the password region, `cmd_addr[1:0]` selects one of the four 16-bit password parts. A program ANDs `cmd_data` into that part.
- R9: A password READ returns the selected part while lock bit 2 is 1. Once bit 2 is 0, it returns 16'hFFFF.
- R10: In the sector region:
  - A program locks the sector numbered `cmd_addr`.
  - A READ returns 16'h0001 for a locked sector and 16'h0000 for an unlocked sector.
  - An address at or above the sector count reads as 16'h0000 and cannot be locked.
- R11: EXIT closes any open region, and `array_en` is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command cycle is present |
| cmd_op | input | 3 | Operation code (R2) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | WORD_W | Command data |
| lock_q | output | 4 | Current lock register |
| mode_pwd | output | 1 | 1 = password protection mode, 0 = persistent mode |
| array_en | output | 1 | No protection region is open; array reads may be served |
| rd_valid | output | 1 | Read data strobe, one cycle after a READ |
| rd_data | output | WORD_W | Status or verify word |

## Verification
The bench builds the unit with NSECT=8 and ADDR_W=8. This puts both the highest sector (7) and an out-of-range address (9) within reach, so the range guard is tested on both sides. The word width stays at 16, which is needed for the four password parts to cover 64 bits. The password is verified before the password-mode bit is cleared, so that the hidden readback is seen changing state.

// File: rtl/plk_pkg.sv
// Shared types for the protection-mode lock unit.
// Assumes the command decoder presents these operation codes.
package plk_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ENTRY = 3'd1,
        OP_SETUP = 3'd2,
        OP_PROG  = 3'd3,
        OP_READ  = 3'd4,
        OP_EXIT  = 3'd5
    } plk_op_e;

    typedef enum logic [1:0] {
        RG_ARRAY = 2'd0,
        RG_LOCK  = 2'd1,
        RG_PWD   = 2'd2,
        RG_SECT  = 2'd3
    } plk_rgn_e;

    localparam int LOCK_W  = 4;
    localparam int LB_PERS = 1;
    localparam int LB_PWD  = 2;
    localparam int LB_OTP  = 3;
endpackage

// File: rtl/plk_seq.sv
// Region sequencer: tracks which protection region is open and whether
// a SETUP cycle has armed the next PROG. Assumes one command per cycle.
module plk_seq
    import plk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  plk_op_e  op,
    input  logic [1:0] entry_sel,
    output plk_rgn_e region,
    output logic     prog_stb,
    output logic     read_stb
);
    logic armed;

    // Region and arming state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region <= RG_ARRAY;
            armed  <= 1'b0;
        end else if (cmd_valid) begin
            armed <= 1'b0;
            case (op)
                OP_ENTRY: if (region == RG_ARRAY && entry_sel != 2'd3)
                              region <= plk_rgn_e'(entry_sel + 2'd1);
                OP_SETUP: armed  <= (region != RG_ARRAY);
                OP_EXIT:  region <= RG_ARRAY;
                default:  ;
            endcase
        end
    end

    // Strobes for the storage blocks
    always_comb begin
        prog_stb = cmd_valid && op == OP_PROG && armed && region != RG_ARRAY;
        read_stb = cmd_valid && op == OP_READ && region != RG_ARRAY;
    end
endmodule

// File: rtl/plk_lockreg.sv
// One-time lock register. Bits move only 1->0, mode bits stay exclusive,
// and a cleared OTP bit freezes the register. Reset models erased cells.
module plk_lockreg
    import plk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic [LOCK_W-1:0] wr_bits,
    output logic [LOCK_W-1:0] lock_q
);
    logic [LOCK_W-1:0] next_bits;
    logic              both_modes;
    logic              frozen;

    // Candidate value and abort/freeze conditions
    always_comb begin
        next_bits  = lock_q & wr_bits;
        both_modes = !next_bits[LB_PERS] && !next_bits[LB_PWD];
        frozen     = !lock_q[LB_OTP];
    end

    // Commit a permitted program
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '1;
        else if (prog && !both_modes && !frozen)
            lock_q <= next_bits;
    end
endmodule

// File: rtl/plk_pwd.sv
// Password store of PARTS words. Each part is programmed 1->0 only,
// and readback is hidden once the password-mode bit is set.
module plk_pwd #(
    parameter int WORD_W = 16,
    parameter int PARTS  = 4,
    localparam int SEL_W = (PARTS > 1) ? $clog2(PARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              hidden,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] part_q [PARTS];

    for (genvar p = 0; p < PARTS; p++) begin : g_part
        // Program one password part when addressed and not yet hidden
        always_ff @(posedge clk) begin
            if (!rst_n)
                part_q[p] <= '1;
            else if (prog && !hidden && sel == SEL_W'(p))
                part_q[p] <= part_q[p] & wdata;
        end
    end

    // Verify readback, masked once the password mode is locked
    always_comb rd_word = hidden ? '1 : part_q[sel];
endmodule

// File: rtl/plk_sect.sv
// Per-sector lock flags (1 = unlocked). Addresses at or above NSECT
// are ignored for programming and read as unlocked.
module plk_sect #(
    parameter int NSECT  = 16,
    parameter int ADDR_W = 8,
    localparam int SAW   = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    logic [NSECT-1:0] unl_q;
    logic             in_range;

    always_comb in_range = {{32-ADDR_W{1'b0}}, addr} < NSECT;

    for (genvar s = 0; s < NSECT; s++) begin : g_sec
        // Lock the addressed sector
        always_ff @(posedge clk) begin
            if (!rst_n)
                unl_q[s] <= 1'b1;
            else if (prog && addr == ADDR_W'(s))
                unl_q[s] <= 1'b0;
        end
    end

    // Status of the addressed sector
    always_comb locked = in_range && !unl_q[addr[SAW-1:0]];
endmodule

// File: rtl/prot_mode_lock.sv
// Top of the protection-mode lock unit: sequencer, lock register,
// password store and sector flags, plus a registered read mux.
// Assumes WORD_W >= 4 and commands already decoded upstream.
module prot_mode_lock
    import plk_pkg::*;
#(
    parameter int NSECT  = 16,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16,
    localparam int PARTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    output logic [LOCK_W-1:0] lock_q,
    output logic              mode_pwd,
    output logic              array_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    plk_rgn_e          region;
    logic              prog_stb, read_stb;
    logic [WORD_W-1:0] pwd_word;
    logic              sec_locked;

    plk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .op(plk_op_e'(cmd_op)), .entry_sel(cmd_data[1:0]),
        .region(region), .prog_stb(prog_stb), .read_stb(read_stb)
    );

    plk_lockreg u_lock (
        .clk(clk), .rst_n(rst_n),
        .prog(prog_stb && region == RG_LOCK),
        .wr_bits(cmd_data[LOCK_W-1:0]), .lock_q(lock_q)
    );

    plk_pwd #(.WORD_W(WORD_W), .PARTS(PARTS)) u_pwd (
        .clk(clk), .rst_n(rst_n),
        .prog(prog_stb && region == RG_PWD),
        .hidden(!lock_q[LB_PWD]), .sel(cmd_addr[1:0]),
        .wdata(cmd_data), .rd_word(pwd_word)
    );

    plk_sect #(.NSECT(NSECT), .ADDR_W(ADDR_W)) u_sect (
        .clk(clk), .rst_n(rst_n),
        .prog(prog_stb && region == RG_SECT),
        .addr(cmd_addr), .locked(sec_locked)
    );

    // Mode and array gating outputs
    always_comb begin
        mode_pwd = !lock_q[LB_PWD];
        array_en = (region == RG_ARRAY);
    end

    // Registered status/verify readout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= read_stb;
            if (read_stb) begin
                case (region)
                    RG_LOCK: rd_data <= {{(WORD_W-LOCK_W){1'b1}}, lock_q};
                    RG_PWD:  rd_data <= pwd_word;
                    default: rd_data <= WORD_W'(sec_locked);
                endcase
            end
        end
    end
endmodule

// File: rtl/prot_mode_lock_chk.sv
// Property checker for the protection-mode lock unit, bound to the top.
module prot_mode_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [3:0] lock_q,
    input logic       mode_pwd,
    input logic       array_en,
    input logic       rd_valid
);
    // R5
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[2:1] != 2'b00);

    // R4
    no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & ~$past(lock_q)) == 4'b0000));

    // R7
    otp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_q[3] |=> $stable(lock_q));

    // R11
    exit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd5) |=> array_en);

    // R4
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(array_en));

    // R6
    mode_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pwd |-> !lock_q[2]);
endmodule

bind prot_mode_lock prot_mode_lock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lock_q(lock_q), .mode_pwd(mode_pwd), .array_en(array_en),
    .rd_valid(rd_valid)
);

// File: tb/prot_mode_lock_test.sv
// Directed bench for prot_mode_lock; one task per scenario.
module prot_mode_lock_test;
    localparam int NSECT = 8, ADDR_W = 8, WORD_W = 16;
    localparam logic [2:0] NOP = 0, ENTRY = 1, SETUP = 2, PROG = 3, READ = 4, EXIT = 5;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [WORD_W-1:0] cmd_data = '0;
    logic [3:0] lock_q;
    logic mode_pwd, array_en, rd_valid;
    logic [WORD_W-1:0] rd_data;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    prot_mode_lock #(.NSECT(NSECT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock_q(lock_q),
        .mode_pwd(mode_pwd), .array_en(array_en), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one command for one cycle, then idle the bus
    task automatic issue(logic [2:0] op, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = NOP;
    endtask

    task automatic prog(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
        issue(SETUP, '0, '0);
        issue(PROG, a, d);
    endtask

    // Read: output is registered at the READ edge, sampled at the next negedge
    task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [WORD_W-1:0] exp);
        issue(READ, a, '0);
        check(req, {31'b0, rd_valid}, 32'd1);
        check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        check("R1 lock", lock_q, 4'hF);
        check("R1 array_en", array_en, 1);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 mode_pwd", mode_pwd, 0);
    endtask

    task automatic t_gate();
        issue(READ, 0, 0);
        check("R4 read ignored in array", rd_valid, 0);
        issue(ENTRY, 0, 3);
        check("R2 entry code 3 ignored", array_en, 1);
        issue(ENTRY, 0, 2);
        check("R2 region open", array_en, 0);
        issue(ENTRY, 0, 0);
        rd_chk("R2 nested entry ignored", 0, 16'h0000);
        issue(EXIT, 0, 0);
        check("R11 exit", array_en, 1);
    endtask

    task automatic t_sect();
        issue(ENTRY, 0, 2);
        prog(5, 0);
        rd_chk("R10 locked", 5, 16'h0001);
        rd_chk("R10 unlocked", 4, 16'h0000);
        issue(PROG, 2, 0);
        rd_chk("R3 prog without setup", 2, 16'h0000);
        issue(SETUP, 0, 0); issue(NOP, 0, 0); issue(PROG, 3, 0);
        rd_chk("R3 setup not adjacent", 3, 16'h0000);
        prog(7, 0);
        rd_chk("R10 top sector", 7, 16'h0001);
        prog(9, 0);
        rd_chk("R10 out of range", 9, 16'h0000);
        rd_chk("R10 alias untouched", 1, 16'h0000);
        issue(EXIT, 0, 0);
    endtask

    task automatic t_pwd();
        issue(ENTRY, 0, 1);
        prog(0, 16'h1234); prog(1, 16'hABCD); prog(2, 16'h5A5A); prog(3, 16'h0F0F);
        rd_chk("R8 part0", 0, 16'h1234);
        rd_chk("R8 part1", 1, 16'hABCD);
        rd_chk("R8 part2", 2, 16'h5A5A);
        rd_chk("R8 part3", 3, 16'h0F0F);
        prog(0, 16'hFF0F);
        rd_chk("R8 and-program", 0, 16'h1204);
        prog(1, 16'hFFFF);
        rd_chk("R8 no raise", 1, 16'hABCD);
        rd_chk("R9 visible before lock", 2, 16'h5A5A);
        issue(EXIT, 0, 0);
    endtask

    task automatic t_lock();
        issue(ENTRY, 0, 0);
        rd_chk("R4 read format", 0, 16'hFFFF);
        prog(0, 16'h0009);
        rd_chk("R5 both modes aborted", 0, 16'hFFFF);
        check("R6 still persistent", mode_pwd, 0);
        prog(0, 16'h000B);
        rd_chk("R4 password mode bit", 0, 16'hFFFB);
        check("R6 password mode", mode_pwd, 1);
        prog(0, 16'h000D);
        rd_chk("R5 second mode bit aborted", 0, 16'hFFFB);
        prog(0, 16'h000F);
        rd_chk("R4 no raise", 0, 16'hFFFB);
        prog(0, 16'h0007);
        rd_chk("R7 otp cleared", 0, 16'hFFF3);
        prog(0, 16'h000E);
        rd_chk("R7 frozen", 0, 16'hFFF3);
        issue(EXIT, 0, 0);
        issue(ENTRY, 0, 1);
        rd_chk("R9 hidden part0", 0, 16'hFFFF);
        rd_chk("R9 hidden part3", 3, 16'hFFFF);
        issue(EXIT, 0, 0);
        check("R11 array back", array_en, 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_sect();
        t_pwd();
        t_lock();
        finish_run();
    end
endmodule